// File: doc/BRIEF.md
# Remote terminal subsystem control logic

This block sits between the protocol core of a serial command/response bus remote terminal and the local subsystem that produces and consumes data words. The core hands it each validated command word with a one-cycle strobe. The core also supplies the in-command level, a running word counter, per-word transfer strobes, a message-error flag and an end-of-message strobe. From these the block produces several outputs for the subsystem: latched subaddress lines, word-count address lines, a gated data request with a direction control, and three status-word flag bits. It also produces two timed active-low pulses: one marks the start of a response to a new command, and one reports a good received data block.

The subsystem drives three active-low flag inputs: busy, subsystem flag and terminal flag. The block samples them into the status bits only when the core signals a status-word update. The set busy bit suppresses data requests for transmit commands, while receive data still flows. The five terminal address straps and their parity strap are checked for odd parity. When that check fails, the block discards every command and raises no pulse.

Top module: `rt_subsys_if`

## Requirements
- R1: The command word is split as terminal address [15:11], transmit flag [10] (1 = transmit), subaddress [9:5] and word count [4:0]. A subaddress of all zeros or all ones marks a mode command. `wc_out` shows the latched word-count field while `in_cmd` is low or the latched command is a mode command. Otherwise it shows `word_cnt` directly.
- R2: `sa_out` holds the subaddress field of the last accepted command, from the clock edge that accepts it.
- R3: On a clock edge with `status_upd` high, each status bit takes the inverse of its active-low input, so a low input sets the bit. At all other edges the status bits hold.
- R4: `sub_req_n` goes low one cycle after `core_req` is high, unless the latched command is a transmit command and `stat_busy` is set. In that case it stays high. Receive commands are requested regardless of busy.
- R5: `dir_rd` is high only in a cycle where a request is active for a transmit command. Otherwise it is low.
- R6: `resp_en` is high exactly when the five address straps plus `addr_par` hold an odd number of ones. While it is low, `cmd_valid` and `msg_done` are ignored: no field is latched and no pulse starts.
- R7: An accepted command drives `newcmd_n` low for 3 cycles, starting the cycle after the accepting edge. A new command restarts the count.
- R8: `goodblk_n` goes low for 8 cycles after a `msg_done` edge, but only when all of the following hold: the latched command is a non-mode receive command, the number of `xfer_done` strobes since it was accepted equals the expected count, and `msg_err` was not seen since acceptance, including in the `msg_done` cycle.
- R9: A word-count field of 0 expects 32 transferred words.
- R10: Synchronous active-low `rst_n` clears the latched fields, the status bits and the counters. It drives `sub_req_n`, `newcmd_n` and `goodblk_n` high and `dir_rd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: validated command on `cmd_word` |
| cmd_word | input | 16 | Command word from the core |
| in_cmd | input | 1 | High while the core is processing the command |
| word_cnt | input | 5 | Running word counter of the core |
| msg_err | input | 1 | Message error seen by the core |
| msg_done | input | 1 | One-cycle strobe at the end of a message |
| xfer_done | input | 1 | One-cycle strobe per word moved to the subsystem |
| core_req | input | 1 | Core wants a data word transfer |
| status_upd | input | 1 | Status word is being updated |
| busy_n | input | 1 | Subsystem busy, active low |
| ssflag_n | input | 1 | Subsystem flag, active low |
| tflag_n | input | 1 | Terminal flag, active low |
| addr_straps | input | 5 | Terminal address straps |
| addr_par | input | 1 | Address parity strap |
| sa_out | output | 5 | Latched subaddress lines |
| wc_out | output | 5 | Word-count / counter address lines |
| stat_busy | output | 1 | Status busy bit |
| stat_ssflag | output | 1 | Status subsystem flag bit |
| stat_tflag | output | 1 | Status terminal flag bit |
| sub_req_n | output | 1 | Data request to the subsystem, active low |
| dir_rd | output | 1 | High: read data from the subsystem |
| resp_en | output | 1 | Address parity good, terminal may respond |
| newcmd_n | output | 1 | New-protocol pulse, active low |
| goodblk_n | output | 1 | Good-block pulse, active low |

## Verification
The hardest case to reach is a good-block pulse for a 32-word receive. It needs a zero word-count field followed by exactly 32 transfer strobes with no error, then the end strobe. The bench drives that sequence directly and counts the low cycles of the pulse. The busy gating needs a status update with busy low before a transmit command. The bench orders those steps explicitly, then clears busy to show the request return. A long stretch of mixed random strobes, subaddresses and strap values is then compared against a behavioural model on every cycle.

// File: rtl/rt_subsys_pkg.sv
// Shared field widths, the command word layout and mode detection.
package rt_subsys_pkg;
    localparam int FIELD_W = 5;
    localparam int WORD_W  = 16;

    typedef struct packed {
        logic [FIELD_W-1:0] rta;
        logic               tx;
        logic [FIELD_W-1:0] sa;
        logic [FIELD_W-1:0] wc;
    } cmd_word_t;

    // A subaddress of all zeros or all ones selects a mode command.
    function automatic logic sa_is_mode(input logic [FIELD_W-1:0] sa);
        return (sa == '0) || (sa == '1);
    endfunction
endpackage

// File: rtl/rt_cmd_latch.sv
// Latches the fields of each accepted command and multiplexes the
// word-count address lines between the latched field and the live counter.
// Assumes cmd_take is a one-cycle strobe already qualified by parity.
module rt_cmd_latch
    import rt_subsys_pkg::*;
#(
    parameter int FW = FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_take,
    input  cmd_word_t     cmd_in,
    input  logic          in_cmd,
    input  logic [FW-1:0] word_cnt,
    output logic [FW-1:0] sa_out,
    output logic [FW-1:0] wc_out,
    output logic [FW-1:0] lat_wc,
    output logic          lat_tx,
    output logic          lat_mode
);
    logic [FW-1:0] sa_q;
    logic [FW-1:0] wc_q;
    logic          tx_q;

    // Capture subaddress, word count and direction of an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_q <= '0;
            wc_q <= '0;
            tx_q <= 1'b0;
        end else if (cmd_take) begin
            sa_q <= cmd_in.sa;
            wc_q <= cmd_in.wc;
            tx_q <= cmd_in.tx;
        end
    end

    // Choose latched field or live counter for the word-count lines.
    always_comb begin
        lat_mode = sa_is_mode(sa_q);
        wc_out   = (!in_cmd || lat_mode) ? wc_q : word_cnt;
    end

    assign sa_out = sa_q;
    assign lat_wc = wc_q;
    assign lat_tx = tx_q;
endmodule

// File: rtl/rt_status_xfer.sv
// Samples the active-low subsystem flags into status bits on each status
// update and produces the gated data request and direction control.
// Bit 0 of the flag vector must be the busy flag.
module rt_status_xfer #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             status_upd,
    input  logic [NFLAG-1:0] flag_n_in,
    input  logic             core_req,
    input  logic             lat_tx,
    output logic [NFLAG-1:0] stat_bits,
    output logic             sub_req_n,
    output logic             dir_rd
);
    localparam int BUSY_BIT = 0;

    logic [NFLAG-1:0] bits_q;
    logic             req_q;
    logic             rd_q;
    logic             allow;

    // One sampling flop per status bit, loaded only on a status update.
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          bits_q[i] <= 1'b0;
            else if (status_upd) bits_q[i] <= ~flag_n_in[i];
        end
    end

    // Busy suppresses requests for transmit commands only.
    assign allow = core_req && !(lat_tx && bits_q[BUSY_BIT]);

    // Register the request and its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            req_q <= allow;
            rd_q  <= allow && lat_tx;
        end
    end

    assign stat_bits = bits_q;
    assign sub_req_n = ~req_q;
    assign dir_rd    = rd_q;
endmodule

// File: rtl/rt_block_check.sv
// Counts words moved to the subsystem for the current command, tracks
// message errors and decides at end of message whether a good block arrived.
// Assumes cmd_take restarts the count and msg_done is a one-cycle strobe.
module rt_block_check #(
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_take,
    input  logic          xfer_done,
    input  logic          msg_err,
    input  logic          msg_done,
    input  logic          par_ok,
    input  logic          lat_tx,
    input  logic          lat_mode,
    input  logic [FW-1:0] lat_wc,
    output logic          gb_fire
);
    localparam int CW = FW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(1) << FW;
    localparam logic [CW-1:0] CNT_MAX  = '1;

    logic [CW-1:0] cnt_q;
    logic          err_q;
    logic [CW-1:0] expect_cnt;

    // Word counter, restarted per command and saturating at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (cmd_take)                    cnt_q <= '0;
        else if (xfer_done && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky message-error flag for the current command.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_q <= 1'b0;
        else if (cmd_take) err_q <= 1'b0;
        else if (msg_err)  err_q <= 1'b1;
    end

    // A zero field expects the full count; judge the block at end of message.
    always_comb begin
        expect_cnt = (lat_wc == '0) ? FULL_CNT : CW'(lat_wc);
        gb_fire    = msg_done && par_ok && !lat_tx && !lat_mode &&
                     !err_q && !msg_err && (cnt_q == expect_cnt);
    end
endmodule

// File: rtl/rt_pulse_stretch.sv
// Turns a one-cycle trigger into an active-low pulse of CYC clock cycles,
// starting the cycle after the trigger; a new trigger restarts the count.
module rt_pulse_stretch #(
    parameter int CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse_n
);
    localparam int CNT_W = $clog2(CYC + 1);

    logic [CNT_W-1:0] left_q;

    // Load on trigger, otherwise count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)           left_q <= '0;
        else if (fire)        left_q <= CNT_W'(CYC);
        else if (left_q != 0) left_q <= left_q - 1'b1;
    end

    assign pulse_n = (left_q == '0);
endmodule

// File: rtl/rt_subsys_if.sv
// Top of the remote terminal subsystem control logic: address parity gate,
// command latch, status sampling with request gating, block check and the
// two timed pulses. Inputs are synchronous to clk.
module rt_subsys_if
    import rt_subsys_pkg::*;
#(
    parameter int FW     = FIELD_W,
    parameter int WW     = WORD_W,
    parameter int NP_CYC = 3,
    parameter int GB_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [WW-1:0] cmd_word,
    input  logic          in_cmd,
    input  logic [FW-1:0] word_cnt,
    input  logic          msg_err,
    input  logic          msg_done,
    input  logic          xfer_done,
    input  logic          core_req,
    input  logic          status_upd,
    input  logic          busy_n,
    input  logic          ssflag_n,
    input  logic          tflag_n,
    input  logic [FW-1:0] addr_straps,
    input  logic          addr_par,
    output logic [FW-1:0] sa_out,
    output logic [FW-1:0] wc_out,
    output logic          stat_busy,
    output logic          stat_ssflag,
    output logic          stat_tflag,
    output logic          sub_req_n,
    output logic          dir_rd,
    output logic          resp_en,
    output logic          newcmd_n,
    output logic          goodblk_n
);
    logic          par_ok;
    logic          cmd_take;
    logic          gb_fire;
    logic          lat_tx;
    logic          lat_mode;
    logic [FW-1:0] lat_wc;
    logic [2:0]    stat_bits;
    cmd_word_t     cmd_s;

    // Odd parity over straps and parity bit qualifies every command.
    always_comb begin
        par_ok   = ^{addr_straps, addr_par};
        cmd_take = cmd_valid && par_ok;
        cmd_s    = cmd_word_t'(cmd_word);
    end

    rt_cmd_latch #(.FW(FW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_take (cmd_take),
        .cmd_in   (cmd_s),
        .in_cmd   (in_cmd),
        .word_cnt (word_cnt),
        .sa_out   (sa_out),
        .wc_out   (wc_out),
        .lat_wc   (lat_wc),
        .lat_tx   (lat_tx),
        .lat_mode (lat_mode)
    );

    rt_status_xfer #(.NFLAG(3)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_upd (status_upd),
        .flag_n_in  ({tflag_n, ssflag_n, busy_n}),
        .core_req   (core_req),
        .lat_tx     (lat_tx),
        .stat_bits  (stat_bits),
        .sub_req_n  (sub_req_n),
        .dir_rd     (dir_rd)
    );

    rt_block_check #(.FW(FW)) u_blk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_take  (cmd_take),
        .xfer_done (xfer_done),
        .msg_err   (msg_err),
        .msg_done  (msg_done),
        .par_ok    (par_ok),
        .lat_tx    (lat_tx),
        .lat_mode  (lat_mode),
        .lat_wc    (lat_wc),
        .gb_fire   (gb_fire)
    );

    rt_pulse_stretch #(.CYC(NP_CYC)) u_np (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (cmd_take),
        .pulse_n (newcmd_n)
    );

    rt_pulse_stretch #(.CYC(GB_CYC)) u_gb (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (gb_fire),
        .pulse_n (goodblk_n)
    );

    assign stat_busy   = stat_bits[0];
    assign stat_ssflag = stat_bits[1];
    assign stat_tflag  = stat_bits[2];
    assign resp_en     = par_ok;
endmodule

// File: rtl/rt_subsys_if_chk.sv
// Property checker for rt_subsys_if, attached to every instance by bind.
module rt_subsys_if_chk #(
    parameter int FW = 5,
    parameter int WW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [WW-1:0] cmd_word,
    input logic          msg_done,
    input logic          core_req,
    input logic          status_upd,
    input logic          busy_n,
    input logic          ssflag_n,
    input logic          tflag_n,
    input logic [FW-1:0] sa_out,
    input logic          stat_busy,
    input logic          stat_ssflag,
    input logic          stat_tflag,
    input logic          sub_req_n,
    input logic          dir_rd,
    input logic          resp_en,
    input logic          newcmd_n,
    input logic          goodblk_n
);
    // R3: sampled on update, held otherwise
    a_r3_sample: assert property (@(posedge clk) disable iff (!rst_n)
        status_upd |=> ({stat_tflag, stat_ssflag, stat_busy} ==
                        ~$past({tflag_n, ssflag_n, busy_n})));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !status_upd |=> $stable({stat_tflag, stat_ssflag, stat_busy}));
    // R4: no request without core demand; busy blocks reads
    a_r4_no_spurious_req: assert property (@(posedge clk) disable iff (!rst_n)
        !core_req |=> sub_req_n);
    a_r4_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        stat_busy |=> !dir_rd);
    // R5: reading only while requesting
    a_r5_dir_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rd |-> !sub_req_n);
    // R6: bad parity leaves latched fields and the pulse untouched
    a_r6_ignore_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !resp_en && newcmd_n) |=> ($stable(sa_out) && newcmd_n));
    // R7: pulse lasts more than one cycle
    a_r7_np_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(newcmd_n) |=> !newcmd_n);
    // R8: good block only follows end of message
    a_r8_gb_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(goodblk_n) |-> $past(msg_done));
endmodule

bind rt_subsys_if rt_subsys_if_chk #(.FW(FW), .WW(WW)) u_chk (.*);

// File: tb/tb_rt_subsys_if.sv
// Self-checking bench: behavioural reference model compared on every cycle.
module tb_rt_subsys_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 0, in_cmd = 0, msg_err = 0, msg_done = 0;
    logic        xfer_done = 0, core_req = 0, status_upd = 0;
    logic        busy_n = 1, ssflag_n = 1, tflag_n = 1, addr_par = 0;
    logic [15:0] cmd_word = 0;
    logic [4:0]  word_cnt = 0, addr_straps = 5'b00001;
    logic [4:0]  sa_out, wc_out;
    logic        stat_busy, stat_ssflag, stat_tflag, sub_req_n, dir_rd;
    logic        resp_en, newcmd_n, goodblk_n;

    int checks = 0, errors = 0;
    bit cmp_en = 0;

    rt_subsys_if dut (.*);

    always #4 clk = ~clk;

    // reference model state
    int m_sa = 0, m_wc = 0, m_tx = 0, m_cnt = 0, m_err = 0;
    int m_np = 0, m_gb = 0, m_req = 0, m_rd = 0;
    int m_busy = 0, m_ssf = 0, m_tf = 0;

    function automatic int parok();
        return ^{addr_straps, addr_par};
    endfunction
    function automatic int is_mode(int sa);
        return (sa == 0 || sa == 31) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int take, fire, expn, allow;
        if (!rst_n) begin
            m_sa = 0; m_wc = 0; m_tx = 0; m_cnt = 0; m_err = 0;
            m_np = 0; m_gb = 0; m_req = 0; m_rd = 0;
            m_busy = 0; m_ssf = 0; m_tf = 0;
        end else begin
            take = cmd_valid && parok();
            expn = (m_wc == 0) ? 32 : m_wc;
            fire = msg_done && parok() && !m_tx && !is_mode(m_sa) &&
                   !m_err && !msg_err && (m_cnt == expn);
            allow = core_req && !(m_tx && m_busy);
            m_req = allow;
            m_rd  = allow && m_tx;
            if (status_upd) begin
                m_busy = !busy_n; m_ssf = !ssflag_n; m_tf = !tflag_n;
            end
            if (fire) m_gb = 8; else if (m_gb > 0) m_gb--;
            if (take) m_np = 3; else if (m_np > 0) m_np--;
            if (take) begin
                m_sa = cmd_word[9:5]; m_wc = cmd_word[4:0]; m_tx = cmd_word[10];
                m_cnt = 0; m_err = 0;
            end else begin
                if (xfer_done && m_cnt < 63) m_cnt++;
                if (msg_err) m_err = 1;
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int ewc;
        if (!cmp_en) return;
        ewc = (!in_cmd || is_mode(m_sa)) ? m_wc : int'(word_cnt);
        chk(wc_out, ewc, "R1 word-count lines");
        chk(sa_out, m_sa, "R2 subaddress lines");
        chk({stat_tflag, stat_ssflag, stat_busy}, {m_tf[0], m_ssf[0], m_busy[0]}, "R3 status bits");
        chk(sub_req_n, !m_req, "R4 data request");
        chk(dir_rd, m_rd, "R5 direction");
        chk(resp_en, parok(), "R6 parity enable");
        chk(newcmd_n, m_np == 0, "R7 new-protocol pulse");
        chk(goodblk_n, m_gb == 0, "R8 good-block pulse");
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            cmd_valid = 0; msg_done = 0; xfer_done = 0; status_upd = 0; msg_err = 0;
        end
    endtask

    task automatic send_cmd(input int tx, input int sa, input int wc);
        cmd_word = {5'd1, tx[0], sa[4:0], wc[4:0]};
        cmd_valid = 1;
        tick();
    endtask

    task automatic words(input int n);
        for (int i = 0; i < n; i++) begin
            xfer_done = 1; word_cnt = 5'(i); tick();
        end
    endtask

    task automatic finish_msg(input int err);
        msg_err = err[0]; msg_done = 1; tick();
    endtask

    initial begin
        int lows;
        tick(3);
        cmp_en = 1;
        // R10: reset state
        chk(sub_req_n, 1, "R10 reset request"); chk(newcmd_n, 1, "R10 reset np");
        chk(goodblk_n, 1, "R10 reset gb");      chk(dir_rd, 0, "R10 reset dir");
        chk(sa_out, 0, "R10 reset sa");         chk(stat_busy, 0, "R10 reset busy");
        rst_n = 1; tick(2);

        // R8: good receive of 4 words, then errored and short blocks
        in_cmd = 1;
        send_cmd(0, 3, 4); words(4); finish_msg(0); tick(10);
        send_cmd(0, 3, 4); words(4); finish_msg(1); tick(10);
        send_cmd(0, 3, 4); words(3); finish_msg(0); tick(10);
        send_cmd(0, 5, 2); words(2); msg_err = 1; tick(); finish_msg(0); tick(10);
        // R1: mode command keeps latched field on the lines
        send_cmd(0, 31, 2); word_cnt = 7; tick(2); words(2); finish_msg(0); tick(10);
        send_cmd(1, 0, 9); word_cnt = 12; tick(2);
        in_cmd = 0; send_cmd(0, 6, 11); word_cnt = 3; tick(2); in_cmd = 1; tick(2);

        // R3/R4/R5: busy blocks transmit requests, not receive
        busy_n = 0; ssflag_n = 0; status_upd = 1; tick(); busy_n = 1; tick();
        send_cmd(1, 4, 2); core_req = 1; tick(3); core_req = 0; tick(2);
        send_cmd(0, 4, 2); core_req = 1; tick(3); core_req = 0; tick(2);
        tflag_n = 0; status_upd = 1; tick(); tflag_n = 1; tick();
        send_cmd(1, 4, 2); core_req = 1; tick(3); core_req = 0; tick(2);

        // R9: zero field expects 32 words
        send_cmd(0, 9, 0); words(32); finish_msg(0);
        lows = (goodblk_n == 0) ? 1 : 0;
        for (int i = 0; i < 10; i++) begin tick(); if (goodblk_n == 0) lows++; end
        chk(lows, 8, "R9 32-word block pulse width");
        send_cmd(0, 9, 0); words(31); finish_msg(0); tick(10);

        // R6: bad parity ignores commands and end of message
        addr_par = 1; send_cmd(0, 17, 1); words(1); finish_msg(0); tick(5);
        chk(sa_out, 9, "R6 ignored subaddress");
        addr_par = 0; tick(2);

        // R7: back-to-back commands restart the pulse
        send_cmd(0, 2, 1); tick(); send_cmd(0, 8, 1); tick(6);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom;
            cmd_word = 16'($urandom);
            if (r[3:0] == 0) cmd_word[9:5] = r[4] ? 5'd31 : 5'd0;
            cmd_valid = (r[8:6] == 0);
            xfer_done = r[9] | r[10];
            msg_done = (r[13:11] == 0);
            msg_err = (r[19:14] == 0);
            core_req = r[20];
            status_upd = (r[22:21] == 0);
            busy_n = r[23]; ssflag_n = r[24]; tflag_n = r[25];
            in_cmd = r[26];
            word_cnt = 5'(r[31:27]);
            if (r[5:0] == 6'h3f) addr_straps = 5'($urandom);
            addr_par = ~^addr_straps ^ (r[5:1] == 0);
            @(negedge clk); compare();
            cmd_valid = 0; msg_done = 0; xfer_done = 0; status_upd = 0; msg_err = 0;
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule